// File: doc/BRIEF.md
# Row-Column Priority Encoder

This block takes a wide request vector and returns the position of the set bit with the lowest index, together with a flag that says whether any bit is set. The vector is folded into a grid of rows, each row being `M` bits wide. Every row is reduced to one status bit by an OR. One encoder works on the column of row-status bits and another works on the bits of the winning row.

The multiplexer that picks the winning row is not driven by the encoded row number. Its select is a one-hot mask that keeps only the lowest set bit of the row-status vector. Row extraction and row-number encoding therefore run side by side. The row-level encoder is itself built from the same structure, one level inside another, until its width is 16 bits or less. At that width a flat leaf encoder is used.

An optional output register holds the index and the flag. When the register is present, the result of a request vector appears on the outputs one clock after that vector is applied.

Top module: `prio2d_enc`

## Requirements
- R1: `hit_o` is 1 exactly when at least one bit of the applied request vector is 1.
- R2: When several bits are set, `idx_o` gives the lowest set bit position; bit 0 has the highest priority.
- R3: With an all-zero request vector, `idx_o` is 0 and `hit_o` is 0.
- R4: For a single set bit at position p, `idx_o` equals p, formed as (row << log2(M)) | column, where row = p / M and column = p % M.
- R5: With `REG_OUT`=1, outputs change only on a rising clock edge and show the result for the vector applied before that edge; while `rst_ni` is low, both outputs are 0.
- R6: The row select mask contains at most one 1, and it is non-zero exactly when some row status bit is set.
- R7: When any row status bit is set, the row delivered by the multiplexer is non-zero, and the leaf encoders only report positions whose bit is 1.
- R8: The column width `M` may be 4, 8 or 16, and every choice yields the same index for the same vector.
- R9: A request whose only set bits lie in the last row is resolved to the correct position in that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| req_i | input | L | Request vector; bit 0 has the highest priority |
| idx_o | output | log2(L) | Position of the winning bit, 0 when no bit is set |
| hit_o | output | 1 | 1 when any request bit is set |

## Verification
The in-line checks assume that the request vector carries only defined 0/1 values when it is evaluated. They also assume that `L` and `M` are powers of two with `M` no wider than `L`. The bench drives every vector in full right after a falling edge, so each vector is stable and fully known before the rising edge that captures the result. It sets up each instance with legal power-of-two widths only. It applies the same patterns to encoders of several widths and column choices, and each result is compared with a plain linear scan.

// File: rtl/prio2d_pkg.sv
package prio2d_pkg;

    localparam int unsigned LEAF_MAX = 16;

    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    function automatic bit cfg_ok(input int unsigned l, input int unsigned m);
        return is_pow2(l) && (m == 4 || m == 8 || m == 16) && (l >= 4) && (l <= 4096);
    endfunction

endpackage

// File: rtl/pe_leaf.sv
module pe_leaf #(
    parameter int unsigned W  = 4,
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          hit_o
);

    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
        hit_o = |vec_i;
    end

    always_comb begin
        if (!$isunknown(vec_i)) begin
            p_leaf_bit_set_r7: assert (!hit_o || vec_i[idx_o])
                else $error("leaf reports a clear bit");
        end
    end

endmodule

// File: rtl/pe_row_mux.sv
module pe_row_mux #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned M    = 4
) (
    input  logic [ROWS*M-1:0] rows_i,
    input  logic [ROWS-1:0]   sel_i,
    output logic [M-1:0]      row_o
);

    always_comb begin
        row_o = '0;
        for (int r = 0; r < ROWS; r++) begin
            row_o = row_o | (rows_i[r*M +: M] & {M{sel_i[r]}});
        end
    end

endmodule

// File: rtl/pe_node.sv
module pe_node #(
    parameter int unsigned W  = 64,
    parameter int unsigned M  = 4,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          hit_o
);
    import prio2d_pkg::*;

    if (W <= LEAF_MAX) begin : g_leaf
        pe_leaf #(.W(W)) u_leaf (
            .vec_i (vec_i),
            .idx_o (idx_o),
            .hit_o (hit_o)
        );
    end else begin : g_split
        localparam int unsigned N   = W / M;
        localparam int unsigned NW  = $clog2(N);
        localparam int unsigned MW  = $clog2(M);

        logic [N-1:0]  row_or;
        logic [N-1:0]  row_sel;
        logic [M-1:0]  row_bits;
        logic [NW-1:0] row_idx;
        logic [MW-1:0] col_idx;
        logic          row_hit;
        logic          col_hit;

        for (genvar r = 0; r < N; r++) begin : g_row_or
            assign row_or[r] = |vec_i[r*M +: M];
        end

        // look-ahead select: keep lowest set bit of the row status vector
        assign row_sel = row_or & ~(row_or - N'(1));

        pe_row_mux #(.ROWS(N), .M(M)) u_mux (
            .rows_i (vec_i),
            .sel_i  (row_sel),
            .row_o  (row_bits)
        );

        pe_node #(.W(N), .M(M)) u_rows (
            .vec_i (row_or),
            .idx_o (row_idx),
            .hit_o (row_hit)
        );

        pe_leaf #(.W(M)) u_cols (
            .vec_i (row_bits),
            .idx_o (col_idx),
            .hit_o (col_hit)
        );

        assign idx_o = {row_idx, col_idx};
        assign hit_o = row_hit;

        always_comb begin
            if (!$isunknown(vec_i)) begin
                p_sel_onehot_r6: assert ($onehot0(row_sel))
                    else $error("row select has several bits");
                p_sel_cover_r6: assert ((row_sel != '0) == row_hit)
                    else $error("row select disagrees with row encoder");
                p_row_nonzero_r7: assert (!row_hit || col_hit)
                    else $error("selected row is empty");
            end
        end
    end

endmodule

// File: rtl/prio2d_enc.sv
module prio2d_enc #(
    parameter int unsigned L       = 64,
    parameter int unsigned M       = 4,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned IW     = $clog2(L)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [L-1:0]  req_i,
    output logic [IW-1:0] idx_o,
    output logic          hit_o
);
    import prio2d_pkg::*;

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          hit;
    } res_t;

    res_t          res_d;
    res_t          res_q;
    logic [IW-1:0] core_idx;
    logic          core_hit;

    initial begin
        p_cfg_legal_r8: assert (cfg_ok(L, M))
            else $error("illegal L/M configuration");
    end

    pe_node #(.W(L), .M(M)) u_core (
        .vec_i (req_i),
        .idx_o (core_idx),
        .hit_o (core_hit)
    );

    always_comb begin
        res_d     = '0;
        res_d.hit = core_hit;
        res_d.idx = core_hit ? core_idx : '0;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) res_q <= '0;
            else         res_q <= res_d;
        end

        p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !res_q.hit |-> (res_q.idx == '0))
            else $error("index not zero without hit");
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign idx_o = res_q.idx;
    assign hit_o = res_q.hit;

endmodule

// File: tb/test_prio2d_enc.sv
module test_prio2d_enc;

    localparam int ND = 6;
    localparam int WD [ND] = '{4, 16, 64, 256, 64, 256};
    localparam int MD [ND] = '{4, 4, 4, 4, 8, 16};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] rq [ND];

    logic [1:0] idx0;  logic hit0;
    logic [3:0] idx1;  logic hit1;
    logic [5:0] idx2;  logic hit2;
    logic [7:0] idx3;  logic hit3;
    logic [5:0] idx4;  logic hit4;
    logic [7:0] idx5;  logic hit5;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    prio2d_enc #(.L(4),   .M(4))  i_prio2d_enc_a (.clk_i(clk), .rst_ni(rst_n), .req_i(rq[0][3:0]),   .idx_o(idx0), .hit_o(hit0));
    prio2d_enc #(.L(16),  .M(4))  i_prio2d_enc_b (.clk_i(clk), .rst_ni(rst_n), .req_i(rq[1][15:0]),  .idx_o(idx1), .hit_o(hit1));
    prio2d_enc #(.L(64),  .M(4))  i_prio2d_enc   (.clk_i(clk), .rst_ni(rst_n), .req_i(rq[2][63:0]),  .idx_o(idx2), .hit_o(hit2));
    prio2d_enc #(.L(256), .M(4))  i_prio2d_enc_d (.clk_i(clk), .rst_ni(rst_n), .req_i(rq[3]),        .idx_o(idx3), .hit_o(hit3));
    prio2d_enc #(.L(64),  .M(8))  i_prio2d_enc_e (.clk_i(clk), .rst_ni(rst_n), .req_i(rq[4][63:0]),  .idx_o(idx4), .hit_o(hit4));
    prio2d_enc #(.L(256), .M(16)) i_prio2d_enc_f (.clk_i(clk), .rst_ni(rst_n), .req_i(rq[5]),        .idx_o(idx5), .hit_o(hit5));

    function automatic int got_idx(input int d);
        case (d)
            0: return int'(idx0);
            1: return int'(idx1);
            2: return int'(idx2);
            3: return int'(idx3);
            4: return int'(idx4);
            default: return int'(idx5);
        endcase
    endfunction

    function automatic logic got_hit(input int d);
        case (d)
            0: return hit0;
            1: return hit1;
            2: return hit2;
            3: return hit3;
            4: return hit4;
            default: return hit5;
        endcase
    endfunction

    // linear scan model: lowest set position within width w
    function automatic int ref_idx(input logic [255:0] v, input int w);
        for (int i = 0; i < w; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic ref_hit(input logic [255:0] v, input int w);
        for (int i = 0; i < w; i++) if (v[i]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input int d, input int ei, input logic eh, input string tag);
        checks++;
        if (got_idx(d) != ei || got_hit(d) !== eh) begin
            errors++;
            $display("FAIL %s dut L=%0d M=%0d: idx=%0d hit=%0b expected idx=%0d hit=%0b",
                     tag, WD[d], MD[d], got_idx(d), got_hit(d), ei, eh);
        end
    endtask

    task automatic check_all(input string tag);
        for (int d = 0; d < ND; d++)
            chk(d, ref_idx(rq[d], WD[d]), ref_hit(rq[d], WD[d]), tag);
    endtask

    task automatic drive_all(input logic [255:0] v);
        for (int d = 0; d < ND; d++) rq[d] = v;
    endtask

    // inputs set after a falling edge, results read at the next falling edge
    task automatic step_and_check(input string tag);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic t_reset;
        drive_all({256{1'b1}});
        @(posedge clk);
        @(negedge clk);
        for (int d = 0; d < ND; d++) chk(d, 0, 1'b0, "R5 reset");
        rst_n = 1'b1;
        drive_all('0);
        step_and_check("R5 after reset");
    endtask

    task automatic t_zero;
        drive_all('0);
        step_and_check("R3 all zero");
    endtask

    task automatic t_walk;
        for (int p = 0; p < 256; p++) begin
            drive_all(256'(1) << p);
            step_and_check("R4 R8 single bit");
        end
    endtask

    task automatic t_ones;
        drive_all({256{1'b1}});
        step_and_check("R1 R2 all ones");
        drive_all({{128{1'b1}}, 128'b0});
        step_and_check("R2 upper half");
    endtask

    task automatic t_last_row;
        for (int pat = 1; pat < 16; pat++) begin
            for (int d = 0; d < ND; d++) begin
                rq[d] = '0;
                for (int b = 0; b < 4; b++)
                    if (pat[b]) rq[d][WD[d] - MD[d] + b] = 1'b1;
                rq[d][WD[d] - 1] = 1'b1;
            end
            step_and_check("R9 last row");
        end
    endtask

    task automatic t_latency;
        drive_all(256'h10);
        @(negedge clk);
        drive_all(256'h100);
        #2;
        for (int d = 1; d < ND; d++) chk(d, 4, 1'b1, "R5 holds until edge");
        @(negedge clk);
        for (int d = 1; d < ND; d++) chk(d, 8, 1'b1, "R5 one cycle later");
    endtask

    task automatic t_random;
        for (int n = 0; n < 200; n++) begin
            logic [255:0] v;
            for (int k = 0; k < 8; k++) begin
                if (n[0]) v[k*32 +: 32] = $urandom() & $urandom() & $urandom() & $urandom();
                else      v[k*32 +: 32] = $urandom() | $urandom();
            end
            if (n % 7 == 0) v = v & ({256{1'b1}} << (n % 250));
            drive_all(v);
            step_and_check("R1 R2 R6 R7 random");
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        drive_all('0);
        @(negedge clk);
        t_reset();
        t_zero();
        t_walk();
        t_ones();
        t_last_row();
        t_latency();
        t_random();
        t_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule